// File: doc/BRIEF.md
# Lightweight 64-bit Block Encryptor (80-bit key)

This block encrypts one 64-bit data word under an 80-bit key using a substitution-permutation network of 31 rounds. It works iteratively: one round per clock, with the round keys derived on the fly from a single 80-bit key register. No key expansion memory is needed. A run takes 32 clock cycles from the edge that first samples the start level high to the edge that raises the ready flag.

The handshake uses a level. The user sets key and plaintext, then raises `start` and holds it high. While `start` stays high the core runs and then holds its result, with `ready` high and the ciphertext shown on `cipherText`. Lowering `start` at any point returns the core to idle. During a run this abandons the computation. After a run it releases the result. While idle the core keeps reloading its inputs, so it is ready for the next block at once.

Each round mixes the upper 64 bits of the key register into the state. It then substitutes every nibble through a fixed 4-bit table and scatters the bits with a fixed permutation, and the key register is then advanced. The last of the 32 cycles only mixes in the final round key.

Top module: `present80_enc`

## Requirements
- R1: While `rst` is high and after it is released with `start` low, `ready` is 0 and `cipherText` is all zeros.
- R2: When `start` is sampled high at a rising edge in idle, `ready` goes to 1 right after the 32nd rising edge that follows. It stays 0 before that.
- R3: The result is the 31-round cipher. Each round does three things in order: XOR of key register bits 79..16 into the state; nibble substitution by the table 0..F -> C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2; and a move of state bit i to bit (16*i) mod 63 for i < 63, with bit 63 fixed. After the 31 rounds, a final XOR with key bits 79..16 gives the output.
- R4: After round r (1..31), the key register is updated in three steps, in this order: it is rotated left by 61 bits, its bits 79..76 pass through the substitution table, and bits 19..15 are XORed with r.
- R5: An all-zero key with all-zero plaintext gives 5579C1387B228445. An all-ones key with all-ones plaintext gives 3333DCD3213210D2.
- R6: Key and plaintext are captured at the edge that samples `start` high. Changes to them during the run have no effect on the result.
- R7: If `start` is sampled low during a run, the run is abandoned: `ready` does not rise, and the next high `start` begins a complete new run on the inputs present then.
- R8: While `ready` is 1 and `start` stays high, `ready` and `cipherText` hold their values, whatever happens on `key` and `plainText`.
- R9: When `start` is sampled low while `ready` is 1, `ready` is 0 after that edge. `cipherText` reads all zeros whenever `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Level: high to run and hold the result, low to abort or release |
| key | input | 80 | Cipher key, stable when `start` rises |
| plainText | input | 64 | Data word to encrypt, stable when `start` rises |
| cipherText | output | 64 | Encrypted word, valid while `ready` is 1, zero otherwise |
| ready | output | 1 | High while a finished result is held |

## Verification
The bench builds the block with its default parameters: a 64-bit state, an 80-bit key register and 32 cycles per run. At these values the two published vectors can be checked exactly, and the result flag can be timed to the exact edge. Further blocks are compared against a bit-level reference model written in the bench. The bench drops `start` at several points: in the middle of a run, at the cycle just before completion, and during the result hold. It also changes the data inputs mid-run and during the hold, which covers the abort and capture behaviour of the level handshake.

// File: rtl/present80_pkg.sv
package present80_pkg;

  localparam int STATE_W = 64;
  localparam int KEY_W   = 80;
  localparam int CYCLES  = 32;
  localparam int CNT_W   = $clog2(CYCLES);
  localparam int NIB_N   = STATE_W / 4;
  localparam int RK_LO   = KEY_W - STATE_W;
  localparam int ROT_L   = 61;
  localparam int RC_LO   = 15;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_RUN  = 2'd1,
    CTL_HOLD = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic             load;
    logic             round;
    logic             finish;
    logic             show;
    logic [CNT_W-1:0] roundNum;
  } dpCtrl_t;

  function automatic logic [3:0] sboxNib(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hC;
      4'h1: y = 4'h5;
      4'h2: y = 4'h6;
      4'h3: y = 4'hB;
      4'h4: y = 4'h9;
      4'h5: y = 4'h0;
      4'h6: y = 4'hA;
      4'h7: y = 4'hD;
      4'h8: y = 4'h3;
      4'h9: y = 4'hE;
      4'hA: y = 4'hF;
      4'hB: y = 4'h8;
      4'hC: y = 4'h4;
      4'hD: y = 4'h7;
      4'hE: y = 4'h1;
      default: y = 4'h2;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/present80_ctrl.sv
module present80_ctrl
  import present80_pkg::*;
#(
  parameter int RUN_CYCLES = CYCLES
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output dpCtrl_t dpCtrl,
  output logic    ready
);

  localparam int CW = $clog2(RUN_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(RUN_CYCLES - 1);

  ctlState_t ctlState, ctlNext;
  logic [CW-1:0] roundCnt, roundCntNext;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ctlState <= CTL_IDLE;
      roundCnt <= '0;
    end else begin
      ctlState <= ctlNext;
      roundCnt <= roundCntNext;
    end
  end

  always_comb begin
    ctlNext         = ctlState;
    roundCntNext    = roundCnt;
    dpCtrl          = '0;
    dpCtrl.roundNum = CNT_W'(roundCnt) + CNT_W'(1);
    unique case (ctlState)
      CTL_IDLE: begin
        dpCtrl.load  = 1'b1;
        roundCntNext = '0;
        if (start) ctlNext = CTL_RUN;
      end
      CTL_RUN: begin
        if (!start) begin
          ctlNext = CTL_IDLE;
        end else if (roundCnt == LAST) begin
          dpCtrl.finish = 1'b1;
          ctlNext       = CTL_HOLD;
        end else begin
          dpCtrl.round = 1'b1;
          roundCntNext = roundCnt + CW'(1);
        end
      end
      CTL_HOLD: begin
        dpCtrl.show = 1'b1;
        if (!start) ctlNext = CTL_IDLE;
      end
      default: ctlNext = CTL_IDLE;
    endcase
  end

  assign ready = (ctlState == CTL_HOLD);

endmodule

// File: rtl/present80_datapath.sv
module present80_datapath
  import present80_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  dpCtrl_t            dpCtrl,
  input  logic [KEY_W-1:0]   key,
  input  logic [STATE_W-1:0] plainText,
  output logic [STATE_W-1:0] cipherText
);

  logic [STATE_W-1:0] stateReg;
  logic [KEY_W-1:0]   keyReg;
  logic [STATE_W-1:0] roundKey;
  logic [STATE_W-1:0] mixed;
  logic [STATE_W-1:0] substituted;
  logic [STATE_W-1:0] permuted;
  logic [KEY_W-1:0]   keyRot;
  logic [KEY_W-1:0]   keyNext;

  assign roundKey = keyReg[KEY_W-1:RK_LO];
  assign mixed    = stateReg ^ roundKey;

  for (genvar n = 0; n < NIB_N; n++) begin : g_sbox
    assign substituted[4*n +: 4] = sboxNib(mixed[4*n +: 4]);
  end

  for (genvar b = 0; b < STATE_W - 1; b++) begin : g_perm
    assign permuted[(b * (STATE_W / 4)) % (STATE_W - 1)] = substituted[b];
  end
  assign permuted[STATE_W-1] = substituted[STATE_W-1];

  assign keyRot = {keyReg[KEY_W-ROT_L-1:0], keyReg[KEY_W-1:KEY_W-ROT_L]};

  always_comb begin
    keyNext = keyRot;
    keyNext[KEY_W-1:KEY_W-4] = sboxNib(keyRot[KEY_W-1:KEY_W-4]);
    keyNext[RC_LO +: CNT_W] = keyRot[RC_LO +: CNT_W] ^ dpCtrl.roundNum;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stateReg <= '0;
      keyReg   <= '0;
    end else if (dpCtrl.load) begin
      stateReg <= plainText;
      keyReg   <= key;
    end else if (dpCtrl.round) begin
      stateReg <= permuted;
      keyReg   <= keyNext;
    end else if (dpCtrl.finish) begin
      stateReg <= mixed;
    end
  end

  assign cipherText = dpCtrl.show ? stateReg : '0;

endmodule

// File: rtl/present80_enc.sv
module present80_enc
  import present80_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [KEY_W-1:0]   key,
  input  logic [STATE_W-1:0] plainText,
  output logic [STATE_W-1:0] cipherText,
  output logic               ready
);

  dpCtrl_t dpCtrl;

  present80_ctrl #(.RUN_CYCLES(CYCLES)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .dpCtrl (dpCtrl),
    .ready  (ready)
  );

  present80_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .dpCtrl     (dpCtrl),
    .key        (key),
    .plainText  (plainText),
    .cipherText (cipherText)
  );

endmodule

// File: rtl/present80_enc_chk.sv
module present80_enc_chk
  import present80_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [STATE_W-1:0] cipherText,
  input logic               ready
);

  localparam int HC_W = $clog2(CYCLES + 2) + 1;
  localparam logic [HC_W-1:0] HC_MAX = '1;
  logic [HC_W-1:0] highCnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) highCnt <= '0;
    else if (!start) highCnt <= '0;
    else if (highCnt != HC_MAX) highCnt <= highCnt + 1'b1;
  end

  assert_ready_timing_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (highCnt == HC_W'(CYCLES + 1)));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> (ready && $stable(cipherText)));

  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    !start |=> !ready);

  assert_zero_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (cipherText == '0));

  assert_reset_R1: assert property (@(posedge clk)
    rst |-> (!ready && cipherText == '0));

endmodule

bind present80_enc present80_enc_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .cipherText (cipherText),
  .ready      (ready)
);

// File: tb/tb_present80_enc.sv
`timescale 1ns/1ps
module tb_present80_enc;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [79:0] key;
  logic [63:0] plainText;
  logic [63:0] cipherText;
  logic        ready;

  int nVec = 0;
  int nBad = 0;

  present80_enc dut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .key        (key),
    .plainText  (plainText),
    .cipherText (cipherText),
    .ready      (ready)
  );

  always #10 clk = ~clk;

  localparam logic [3:0] SBOX [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                      4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

  function automatic logic [63:0] refEnc(input logic [63:0] pt, input logic [79:0] k);
    logic [63:0] s, t;
    logic [79:0] kk;
    s  = pt;
    kk = k;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ kk[79:16];
      for (int n = 0; n < 16; n++) s[4*n +: 4] = SBOX[s[4*n +: 4]];
      t = '0;
      for (int i = 0; i < 64; i++) begin
        if (i == 63) t[63] = s[63];
        else t[(16 * i) % 63] = s[i];
      end
      s  = t;
      kk = {kk[18:0], kk[79:19]};
      kk[79:76] = SBOX[kk[79:76]];
      kk[19:15] = kk[19:15] ^ 5'(r);
    end
    return s ^ kk[79:16];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Raise start with the given inputs and count negedges until ready (limit 100).
  task automatic launch(input logic [79:0] k, input logic [63:0] pt, output int waitN);
    @(negedge clk);
    key = k;
    plainText = pt;
    start = 1'b1;
    waitN = 0;
    while (waitN < 100) begin
      @(negedge clk);
      waitN++;
      if (ready) break;
    end
  endtask

  task automatic releaseStart();
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    rst = 1'b1;
    start = 1'b0;
    key = '0;
    plainText = '0;
    #35;
    check("R1 ready in reset", 64'(ready), 64'd0);
    check("R1 output in reset", cipherText, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 ready after reset", 64'(ready), 64'd0);
    check("R1 output after reset", cipherText, 64'd0);
  endtask

  task automatic testKnownVectors();
    int w;
    launch(80'h0, 64'h0, w);
    check("R2 latency zero vector", 64'(w), 64'd33);
    check("R5 zero vector", cipherText, 64'h5579C1387B228445);
    releaseStart();
    launch({80{1'b1}}, {64{1'b1}}, w);
    check("R2 latency ones vector", 64'(w), 64'd33);
    check("R5 ones vector", cipherText, 64'h3333DCD3213210D2);
    releaseStart();
  endtask

  task automatic testModel();
    logic [79:0] ks [4] = '{80'h0123456789ABCDEF0123, 80'hFEDCBA98765432100000,
                            80'h00000000000000000001, 80'h8000_0000_0000_0000_0000};
    logic [63:0] ps [4] = '{64'h0011223344556677, 64'hFFFFFFFFFFFFFFFF,
                            64'h0000000000000000, 64'hDEADBEEFCAFEF00D};
    int w;
    for (int v = 0; v < 4; v++) begin
      launch(ks[v], ps[v], w);
      check("R2 latency model vector", 64'(w), 64'd33);
      check("R3 R4 model vector", cipherText, refEnc(ps[v], ks[v]));
      releaseStart();
    end
  endtask

  task automatic testCapture();
    logic [79:0] k0 = 80'h13579BDF02468ACE1357;
    logic [63:0] p0 = 64'h0F1E2D3C4B5A6978;
    int w;
    @(negedge clk);
    key = k0;
    plainText = p0;
    start = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    key = ~k0;
    plainText = ~p0;
    w = 5;
    while (w < 100) begin
      @(negedge clk);
      w++;
      if (ready) break;
    end
    check("R6 latency with input change", 64'(w), 64'd33);
    check("R6 inputs captured at start", cipherText, refEnc(p0, k0));
    releaseStart();
  endtask

  task automatic testAbort(input int dropAfter);
    logic [79:0] k1 = 80'hA5A5_5A5A_0F0F_F0F0_1234;
    logic [63:0] p1 = 64'h1122334455667788;
    int w;
    logic seen;
    @(negedge clk);
    key = k1;
    plainText = p1;
    start = 1'b1;
    for (int i = 0; i < dropAfter; i++) @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ready) seen = 1'b1;
    end
    check("R7 no ready after abort", 64'(seen), 64'd0);
    check("R9 output zero after abort", cipherText, 64'd0);
    launch(~k1, p1 ^ 64'hFF, w);
    check("R7 full run after abort", 64'(w), 64'd33);
    check("R7 result after abort", cipherText, refEnc(p1 ^ 64'hFF, ~k1));
    releaseStart();
  endtask

  task automatic testHoldAndRelease();
    logic [79:0] k2 = 80'h0000FFFF0000FFFF0000;
    logic [63:0] p2 = 64'hAAAA5555AAAA5555;
    logic [63:0] exp;
    int w;
    exp = refEnc(p2, k2);
    launch(k2, p2, w);
    check("R3 hold vector", cipherText, exp);
    key = ~k2;
    plainText = ~p2;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R8 ready holds", 64'(ready), 64'd1);
      check("R8 output holds", cipherText, exp);
    end
    start = 1'b0;
    @(negedge clk);
    check("R9 ready clears", 64'(ready), 64'd0);
    check("R9 output zero", cipherText, 64'd0);
  endtask

  initial begin
    #3_000_000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    testReset();
    testKnownVectors();
    testModel();
    testCapture();
    testAbort(10);
    testAbort(32);
    testHoldAndRelease();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule